// File: doc/BRIEF.md
# NAND Flash Status Read Logic

This block is the device-side logic of a NAND flash die stack that answers status queries on the 8-bit command interface. It watches the command and address latch strobes, the write enable, the read enable and the chip enable. It decodes command bytes and remembers which kind of data the next read cycles must put on the I/O bus: array data, the combined status byte, or the status of one selected plane on one selected die.

A plain status query reports die 0. Its two fail bits are the OR of the results of all planes, so one read gives the outcome of a multi-plane operation. The enhanced query carries three address cycles. The last of these names a plane and a die, so that several dice behind one shared chip enable can be polled one at a time while they work concurrently. The status byte follows its inputs live, every cycle, and the mode holds until the next command byte arrives.

All strobes are sampled on the block clock. A write-enable rising edge is detected by comparing against the previous sample. The I/O outputs are registered and appear one clock after the inputs they depend on.

Top module: `nand_status_unit`

## Requirements
- R1: After reset, io_oe is 0 and io_out is 00h, the mode is array read, and the enhanced selection is plane 0 on die 0.
- R2: Latching command byte 70h selects plain status mode. While ce_n and re_n are both low, the status byte then appears on io_out, with io_oe at 1, one clock later.
- R3: io_oe is 1 only when, one clock earlier, ce_n and re_n were both low and the mode was array read, plain status or completed enhanced status. Whenever io_oe is 0, io_out is 00h.
- R4: The plain status byte is built as follows. Bit 0 is the OR of die 0's plane pass/fail inputs. Bit 1 is the OR of die 0's plane cache pass/fail inputs. Bits 2 to 4 are 0. Bit 5 is die 0's array-ready input. Bit 6 is die 0's interface-ready input. Bit 7 is wp_n.
- R5: The status byte on io_out follows changes of its inputs one clock later, with no toggling of re_n or ce_n. This also holds when the input changes in the same cycle that a command is latched.
- R6: Status mode holds through any number of re_n cycles. Latching 00h returns to array read mode, where io_out shows array_data.
- R7: Latching any command byte other than 00h, 70h or 78h selects a mode with no output. io_oe then stays 0.
- R8: Command 78h is followed by three address cycles. The third cycle sets the plane from io_in[0] and the die from io_in[2:1]. The output then shows that plane's pass/fail (bit 0) and cache pass/fail (bit 1), together with that die's array ready (bit 5), interface ready (bit 6) and wp_n (bit 7). Until the third address cycle, there is no output.
- R9: An enhanced query that selects a die index at or above DIE_PRESENT (default 2) returns 00h.
- R10: A command is latched only on a rising edge of we_n while cle is 1, ale is 0 and ce_n is 0. Address cycles outside an enhanced-address phase, and bytes written with cle at 0, have no effect.
- R11: The enhanced selection holds across re_n cycles until another command byte is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| we_n | input | 1 | Write enable, active low; bytes latch on its rising edge |
| re_n | input | 1 | Read enable, active low |
| io_in | input | 8 | I/O bus as driven by the host |
| array_data | input | 8 | Array read byte, shown in array read mode |
| plane_pass_fail | input | DIE_SLOTS*NUM_PLANES | Fail flag per plane, index die*NUM_PLANES+plane |
| plane_cache_fail | input | DIE_SLOTS*NUM_PLANES | Cache fail flag per plane, same indexing |
| die_array_rdy | input | DIE_SLOTS | Array ready per die |
| die_if_rdy | input | DIE_SLOTS | Interface ready per die |
| wp_n | input | 1 | Write-protect pin level, 1 = not protected |
| io_out | output | 8 | Byte the block drives on the I/O bus |
| io_oe | output | 1 | Output enable for io_out |

## Verification
The case that needs care is a status input changing in the very cycle a command byte is latched. The bench raises die 0's interface-ready in the cycle of the we_n rising edge that latches 70h, while re_n is already low. It then expects, on the following clocks, the status byte with the new ready bit rather than stale array data or the old bit. A second overlap is a read strobe held low across the command that leaves the mode, which must switch the output in one step. This is judged by checking both the byte and io_oe against values worked out from the command sequence.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  typedef enum logic [2:0] {
    M_ARRAY    = 3'd0,
    M_STATUS   = 3'd1,
    M_ENH_ADDR = 3'd2,
    M_ENH      = 3'd3,
    M_NONE     = 3'd4
  } mode_t;

  localparam logic [7:0] OP_READ     = 8'h00;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_STAT_ENH = 8'h78;
endpackage

// File: rtl/nsr_cmd_decoder.sv
module nsr_cmd_decoder
  import nsr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int ADDR_CYCLES = 3,
  parameter int PLANE_W     = 1,
  parameter int DIE_W       = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce_n,
  input  logic               cle,
  input  logic               ale,
  input  logic               we_n,
  input  logic [DW-1:0]      io_in,
  output mode_t              mode,
  output logic [PLANE_W-1:0] sel_plane,
  output logic [DIE_W-1:0]   sel_die,
  output logic               cmd_stb
);
  localparam int CNT_W = $clog2(ADDR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(ADDR_CYCLES - 1);

  logic             we_q;
  logic             we_rise;
  logic             adr_stb;
  logic [CNT_W-1:0] adr_cnt;

  // write enable edge seen through the clock
  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= we_n;
  end

  assign we_rise = we_n && !we_q && !ce_n;
  assign cmd_stb = we_rise && cle && !ale;
  assign adr_stb = we_rise && ale && !cle;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_ARRAY;
      adr_cnt   <= '0;
      sel_plane <= '0;
      sel_die   <= '0;
    end else if (cmd_stb) begin
      adr_cnt <= '0;
      case (io_in)
        OP_READ:     mode <= M_ARRAY;
        OP_STATUS:   mode <= M_STATUS;
        OP_STAT_ENH: mode <= M_ENH_ADDR;
        default:     mode <= M_NONE;
      endcase
    end else if (adr_stb && mode == M_ENH_ADDR) begin
      if (adr_cnt == LAST_CYC) begin
        sel_plane <= io_in[PLANE_W-1:0];
        sel_die   <= io_in[PLANE_W +: DIE_W];
        mode      <= M_ENH;
        adr_cnt   <= '0;
      end else begin
        adr_cnt <= adr_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nsr_status_mux.sv
module nsr_status_mux #(
  parameter int DW          = 8,
  parameter int NUM_PLANES  = 2,
  parameter int DIE_SLOTS   = 4,
  parameter int DIE_PRESENT = 2,
  parameter int PLANE_W     = 1,
  parameter int DIE_W       = 2
) (
  input  logic [DIE_SLOTS*NUM_PLANES-1:0] plane_pass_fail,
  input  logic [DIE_SLOTS*NUM_PLANES-1:0] plane_cache_fail,
  input  logic [DIE_SLOTS-1:0]            die_array_rdy,
  input  logic [DIE_SLOTS-1:0]            die_if_rdy,
  input  logic                            wp_n,
  input  logic [PLANE_W-1:0]              sel_plane,
  input  logic [DIE_W-1:0]                sel_die,
  output logic [DW-1:0]                   plain_byte,
  output logic [DW-1:0]                   enh_byte
);
  localparam int SLOTS = DIE_SLOTS * NUM_PLANES;

  logic [DW-1:0] slot_byte [SLOTS];

  function automatic logic [DW-1:0] pack_status(input logic pf, input logic cpf,
                                                input logic ardy, input logic irdy,
                                                input logic wp);
    logic [DW-1:0] b;
    b    = '0;
    b[0] = pf;
    b[1] = cpf;
    b[5] = ardy;
    b[6] = irdy;
    b[7] = wp;
    return b;
  endfunction

  genvar d, p;
  generate
    for (d = 0; d < DIE_SLOTS; d++) begin : g_die
      localparam logic PRESENT = (d < DIE_PRESENT);
      for (p = 0; p < NUM_PLANES; p++) begin : g_plane
        assign slot_byte[d*NUM_PLANES+p] =
          pack_status(plane_pass_fail[d*NUM_PLANES+p], plane_cache_fail[d*NUM_PLANES+p],
                      die_array_rdy[d], die_if_rdy[d], wp_n) & {DW{PRESENT}};
      end
    end
  endgenerate

  // combined view of die 0: fail flags OR over its planes
  always_comb begin
    logic pf_any, cpf_any;
    pf_any  = 1'b0;
    cpf_any = 1'b0;
    for (int i = 0; i < NUM_PLANES; i++) begin
      pf_any  = pf_any  | plane_pass_fail[i];
      cpf_any = cpf_any | plane_cache_fail[i];
    end
    plain_byte = pack_status(pf_any, cpf_any, die_array_rdy[0], die_if_rdy[0], wp_n);
  end

  always_comb begin
    int idx;
    idx = int'(sel_die) * NUM_PLANES + int'(sel_plane);
    enh_byte = '0;
    for (int i = 0; i < SLOTS; i++)
      if (i == idx) enh_byte = slot_byte[i];
  end
endmodule

// File: rtl/nsr_io_drive.sv
module nsr_io_drive
  import nsr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          re_n,
  input  mode_t         mode,
  input  logic [DW-1:0] array_data,
  input  logic [DW-1:0] plain_byte,
  input  logic [DW-1:0] enh_byte,
  output logic [DW-1:0] io_out,
  output logic          io_oe
);
  logic          drive_mode;
  logic          oe_next;
  logic [DW-1:0] byte_next;

  always_comb begin
    drive_mode = 1'b1;
    byte_next  = '0;
    case (mode)
      M_ARRAY:  byte_next = array_data;
      M_STATUS: byte_next = plain_byte;
      M_ENH:    byte_next = enh_byte;
      default:  drive_mode = 1'b0;
    endcase
  end

  assign oe_next = drive_mode && !ce_n && !re_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      io_oe  <= 1'b0;
      io_out <= '0;
    end else begin
      io_oe  <= oe_next;
      io_out <= oe_next ? byte_next : '0;
    end
  end
endmodule

// File: rtl/nand_status_unit.sv
module nand_status_unit
  import nsr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NUM_PLANES  = 2,
  parameter int DIE_SLOTS   = 4,
  parameter int DIE_PRESENT = 2,
  parameter int ADDR_CYCLES = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ce_n,
  input  logic                            cle,
  input  logic                            ale,
  input  logic                            we_n,
  input  logic                            re_n,
  input  logic [DW-1:0]                   io_in,
  input  logic [DW-1:0]                   array_data,
  input  logic [DIE_SLOTS*NUM_PLANES-1:0] plane_pass_fail,
  input  logic [DIE_SLOTS*NUM_PLANES-1:0] plane_cache_fail,
  input  logic [DIE_SLOTS-1:0]            die_array_rdy,
  input  logic [DIE_SLOTS-1:0]            die_if_rdy,
  input  logic                            wp_n,
  output logic [DW-1:0]                   io_out,
  output logic                            io_oe
);
  localparam int PLANE_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1;
  localparam int DIE_W   = (DIE_SLOTS > 1) ? $clog2(DIE_SLOTS) : 1;

  mode_t              mode_w;
  logic [PLANE_W-1:0] sel_plane_w;
  logic [DIE_W-1:0]   sel_die_w;
  logic               cmd_stb_w;
  logic [DW-1:0]      plain_w;
  logic [DW-1:0]      enh_w;

  nsr_cmd_decoder #(
    .DW(DW), .ADDR_CYCLES(ADDR_CYCLES), .PLANE_W(PLANE_W), .DIE_W(DIE_W)
  ) dec_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .io_in(io_in), .mode(mode_w), .sel_plane(sel_plane_w), .sel_die(sel_die_w),
    .cmd_stb(cmd_stb_w)
  );

  nsr_status_mux #(
    .DW(DW), .NUM_PLANES(NUM_PLANES), .DIE_SLOTS(DIE_SLOTS),
    .DIE_PRESENT(DIE_PRESENT), .PLANE_W(PLANE_W), .DIE_W(DIE_W)
  ) mux_i (
    .plane_pass_fail(plane_pass_fail), .plane_cache_fail(plane_cache_fail),
    .die_array_rdy(die_array_rdy), .die_if_rdy(die_if_rdy), .wp_n(wp_n),
    .sel_plane(sel_plane_w), .sel_die(sel_die_w),
    .plain_byte(plain_w), .enh_byte(enh_w)
  );

  nsr_io_drive #(.DW(DW)) drv_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .re_n(re_n), .mode(mode_w),
    .array_data(array_data), .plain_byte(plain_w), .enh_byte(enh_w),
    .io_out(io_out), .io_oe(io_oe)
  );
endmodule

// File: rtl/nsr_checker.sv
module nsr_checker
  import nsr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIE_PRESENT = 2,
  parameter int DIE_W       = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ce_n,
  input logic             re_n,
  input logic             io_oe,
  input logic [DW-1:0]    io_out,
  input mode_t            mode,
  input logic [DIE_W-1:0] sel_die,
  input logic             cmd_stb
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!io_oe && io_out == '0));

  // R3
  a_r3_oe_needs_strobes: assert property (@(posedge clk) disable iff (rst)
    io_oe |-> ($past(!ce_n) && $past(!re_n)));

  a_r3_bus_zero_when_off: assert property (@(posedge clk) disable iff (rst)
    !io_oe |-> io_out == '0);

  // R2
  a_r2_status_drives: assert property (@(posedge clk) disable iff (rst)
    (mode == M_STATUS && !ce_n && !re_n) |=> io_oe);

  // R7
  a_r7_no_output_mode: assert property (@(posedge clk) disable iff (rst)
    (mode == M_NONE || mode == M_ENH_ADDR) |=> !io_oe);

  // R9
  a_r9_absent_die_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ENH && int'(sel_die) >= DIE_PRESENT) |=> io_out == '0);

  // R6
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode == M_STATUS && !cmd_stb) |=> mode == M_STATUS);

  // R4
  a_r4_reserved_bits: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) != M_ARRAY) |-> io_out[4:2] == 3'b000);
endmodule

bind nand_status_unit nsr_checker #(
  .DW(DW), .DIE_PRESENT(DIE_PRESENT), .DIE_W(DIE_W)
) chk_i (
  .clk(clk), .rst(rst), .ce_n(ce_n), .re_n(re_n), .io_oe(io_oe), .io_out(io_out),
  .mode(mode_w), .sel_die(sel_die_w), .cmd_stb(cmd_stb_w)
);

// File: tb/nand_status_unit_tb_top.sv
`timescale 1ns/1ps
module nand_status_unit_tb_top;
  localparam int NP = 2;
  localparam int ND = 4;
  localparam int DP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0] io_in = '0, array_data = 8'hA5;
  logic [ND*NP-1:0] pf = '0, cpf = '0;
  logic [ND-1:0] ardy = '0, irdy = '0;
  logic wp_n = 1'b1;
  logic [7:0] io_out;
  logic io_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nand_status_unit dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .io_in(io_in), .array_data(array_data), .plane_pass_fail(pf), .plane_cache_fail(cpf),
    .die_array_rdy(ardy), .die_if_rdy(irdy), .wp_n(wp_n), .io_out(io_out), .io_oe(io_oe)
  );

  function automatic logic [7:0] exp_plain();
    return {wp_n, irdy[0], ardy[0], 3'b000, cpf[1] | cpf[0], pf[1] | pf[0]};
  endfunction

  function automatic logic [7:0] exp_enh(input int d, input int p);
    if (d >= DP) return 8'h00;
    return {wp_n, irdy[d], ardy[d], 3'b000, cpf[d*NP+p], pf[d*NP+p]};
  endfunction

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp_oe, input logic [7:0] exp_b);
    n_vec++;
    if (io_oe !== exp_oe || io_out !== exp_b) begin
      n_bad++;
      $display("FAIL %s: got oe=%b out=%h, expected oe=%b out=%h", req, io_oe, io_out,
               exp_oe, exp_b);
    end
  endtask

  task automatic wr(input logic is_cmd, input logic [7:0] b);
    @(negedge clk);
    cle = is_cmd; ale = !is_cmd; io_in = b; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic enh_sel(input int d, input int p);
    wr(1'b1, 8'h78);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'(d * 2 + p));
  endtask

  initial begin
    waitn(5);
    rst = 1'b0;
    waitn(1);
    check("R1 reset outputs", 1'b0, 8'h00);
    ce_n = 1'b0;
    waitn(2);
    check("R3 re high no drive", 1'b0, 8'h00);
    re_n = 1'b0;
    waitn(2);
    check("R1 reset mode array", 1'b1, 8'hA5);

    wr(1'b1, 8'h70);
    for (int v = 0; v < 64; v++) begin
      pf    = {6'(v * 5), 2'(v)};
      cpf   = {6'(v * 3), 2'(v >> 2)};
      ardy  = {3'(v), v[4]};
      irdy  = {3'(v >> 1), v[5]};
      wp_n  = v[0] ^ v[5];
      waitn(2);
      check("R4 R5 plain status sweep", 1'b1, exp_plain());
    end
    for (int k = 0; k < 5; k++) begin
      re_n = 1'b1;
      waitn(2);
      check("R3 R6 released between reads", 1'b0, 8'h00);
      re_n = 1'b0;
      waitn(2);
      check("R6 status persists", 1'b1, exp_plain());
    end
    ce_n = 1'b1;
    waitn(2);
    check("R3 ce high no drive", 1'b0, 8'h00);
    wr(1'b1, 8'h00);
    ce_n = 1'b0;
    waitn(2);
    check("R10 command with ce high ignored", 1'b1, exp_plain());
    @(negedge clk); io_in = 8'h00; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    waitn(2);
    check("R10 cle low byte ignored", 1'b1, exp_plain());
    wr(1'b0, 8'h00);
    waitn(1);
    check("R10 address in status mode ignored", 1'b1, exp_plain());

    array_data = 8'h3C;
    wr(1'b1, 8'h00);
    waitn(1);
    check("R6 read cmd gives array", 1'b1, 8'h3C);
    wr(1'b1, 8'h90);
    waitn(1);
    check("R7 other cmd no output", 1'b0, 8'h00);
    wr(1'b1, 8'h00);

    // status input change in the latch cycle of 70h
    irdy[0] = 1'b0;
    @(negedge clk);
    cle = 1'b1; io_in = 8'h70; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; irdy[0] = 1'b1;
    @(negedge clk);
    cle = 1'b0;
    waitn(1);
    check("R5 R2 ready change at latch", 1'b1, exp_plain());

    // enhanced select
    wr(1'b1, 8'h78);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h00);
    waitn(1);
    check("R8 no output before last address", 1'b0, 8'h00);
    for (int d = 0; d < ND; d++) begin
      for (int p = 0; p < NP; p++) begin
        enh_sel(d, p);
        for (int k = 0; k < 4; k++) begin
          pf   = 8'(8'h96 ^ (k * 37));
          cpf  = 8'(8'h5A ^ (k * 71));
          ardy = 4'(k * 5 + 3);
          irdy = 4'(k * 3 + 6);
          wp_n = k[0];
          waitn(2);
          if (d >= DP) check("R9 absent die", 1'b1, 8'h00);
          else         check("R8 enhanced status", 1'b1, exp_enh(d, p));
        end
        re_n = 1'b1;
        waitn(2);
        re_n = 1'b0;
        waitn(2);
        check("R11 selection held", 1'b1, exp_enh(d, p));
      end
    end
    wr(1'b1, 8'h70);
    waitn(1);
    check("R11 new command ends enhanced", 1'b1, exp_plain());
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule